// File: doc/BRIEF.md
# Split-Index Cache Tag Controller

This block manages the tag side of a 64 KB, four-way set-associative cache with 128-byte lines. A lookup starts from seven index bits taken from virtual address bits [13:7], so the set read overlaps with address translation. One cycle later the translated 20-bit frame number arrives. It is compared against every way of the chosen set, and the result is reported as a hit with its way, or as a miss.

The top two index bits lie above the 4 KB page offset. They come from the virtual page number and need not equal the low frame bits. For that reason every tag keeps the complete frame number. On a miss the block holds the set that was picked at lookup and chooses a victim. It then presents a line-aligned refill address and, when the victim holds modified data, a line-aligned write-back address. The write-back address is rebuilt from the stored frame number and only the low five index bits. When the memory side signals completion, the new frame number is written into the held set. The data array, the translation unit and the memory bus lie outside the block.

Top module: `vipt_tag_ctrl`

## Requirements
- R1: After reset, busy, respValid, refillReq and wbReq are 0 and every way of every set is invalid, so the first lookup to any set misses.
- R2: The set is selected only by the 7-bit index input (virtual address bits [13:7]). The same frame number used with two indices that differ only in the top two bits addresses two different sets.
- R3: A request accepted in cycle N takes xlatPfn in cycle N+1 and gives respValid=1 in cycle N+2. respHit=1 only when a valid way stores a frame number equal to xlatPfn in all 20 bits, and respWay then names that way (0 to 3).
- R4: On a miss, refillReq rises together with respValid, and refillAddr = {xlatPfn, index[4:0], 7'b0}.
- R5: On a miss, wbAddr = {stored frame number of the victim, index[4:0], 7'b0}, and wbReq=1 only if the victim way is both valid and dirty.
- R6: The victim is the lowest-numbered invalid way of the set. If all four ways are valid, the victim comes from the 3-bit tree state t: if t[0]=0 it is way t[1], otherwise way 2+t[2]. Reset sets t to 0.
- R7: While a miss is outstanding, busy=1 and any request is ignored: no response is produced and the refill and write-back addresses stay unchanged.
- R8: A refillDone pulse during an outstanding miss writes the frame number into the victim way of the set held from the lookup, with valid=1 and dirty=0. In the next cycle refillReq, wbReq and busy are 0.
- R9: A write request that hits sets the dirty bit of the hit way.
- R10: A hit or an install to way w updates the tree state to point away from w: for w<2, t[0]=1 and t[1]=~w[0]; for w>=2, t[0]=0 and t[2]=~w[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request, taken when busy is 0 |
| reqWrite | input | 1 | Request is a store |
| reqVaIndex | input | 7 | Virtual address bits [13:7] of the request |
| xlatPfn | input | 20 | Translated frame number, valid in the cycle after acceptance |
| busy | output | 1 | New requests are not taken |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Lookup hit |
| respWay | output | 2 | Way that hit |
| wbReq | output | 1 | Dirty victim must be written back |
| wbAddr | output | 32 | Line-aligned physical write-back address |
| refillReq | output | 1 | Line refill outstanding |
| refillAddr | output | 32 | Line-aligned physical refill address |
| refillDone | input | 1 | Refill finished, install the tag |

## Verification
The assertions check on every cycle that at most one way matches, that a miss response comes with a refill request, and that a write-back request never appears without a refill. They also check that the refill request is held until completion and released right after it, and that no response appears while a miss waits. The bench scenarios are needed for the values themselves: the address concatenations with mismatching upper index bits, the invalid-first and tree-based victim order, dirty marking by write hits, and clearing of dirty on install. These show up only after sequences of lookups and refills, observed through wbReq, wbAddr and respWay.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int LRU_W = 3;

  typedef struct packed {
    logic capture;    // take the index of a new lookup
    logic hitUpd;     // compare stage hit: refresh tree state
    logic hitWrite;   // compare stage hit is a store: mark dirty
    logic missLatch;  // compare stage miss: hold set, victim, addresses
    logic install;    // refill finished: write tag into held slot
  } ctlStrobe_t;

  function automatic logic [WAY_W-1:0] treeVictim(input logic [LRU_W-1:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [LRU_W-1:0] treeTouch(input logic [LRU_W-1:0] t,
                                                 input logic [WAY_W-1:0] w);
    logic [LRU_W-1:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/vtag_datapath.sv
module vtag_datapath
  import vtag_pkg::*;
#(
  parameter int PFN_W  = 20,
  parameter int IDX_W  = 7,
  parameter int OFF_W  = 7,
  parameter int PAGE_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              strobe,
  input  logic [IDX_W-1:0]        reqIdx,
  input  logic [PFN_W-1:0]        xlatPfn,
  output logic                    hit,
  output logic [WAY_W-1:0]        hitWay,
  output logic                    victimNeedsWb,
  output logic [PFN_W+PAGE_W-1:0] wbAddr,
  output logic [PFN_W+PAGE_W-1:0] refillAddr
);
  localparam int SETS  = 1 << IDX_W;
  localparam int LOW_W = PAGE_W - OFF_W;

  logic [PFN_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [WAYS-1:0]  dirtyMem [SETS];
  logic [LRU_W-1:0] lruMem   [SETS];

  logic [IDX_W-1:0] s1Idx, missIdx;
  logic [WAY_W-1:0] missWay, victim;
  logic [PFN_W-1:0] missPfn;
  logic [WAYS-1:0]  validRow, hitVec;

  assign validRow = validMem[s1Idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validRow[w] && (tagMem[s1Idx][w] == xlatPfn);
  end

  always_comb begin
    hit    = |hitVec;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    victim = treeVictim(lruMem[s1Idx]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validRow[w]) victim = WAY_W'(w);
  end

  assign victimNeedsWb = validRow[victim] && dirtyMem[s1Idx][victim];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Idx      <= '0;
      missIdx    <= '0;
      missWay    <= '0;
      missPfn    <= '0;
      wbAddr     <= '0;
      refillAddr <= '0;
    end else begin
      if (strobe.capture) s1Idx <= reqIdx;
      if (strobe.missLatch) begin
        missIdx    <= s1Idx;
        missWay    <= victim;
        missPfn    <= xlatPfn;
        refillAddr <= {xlatPfn, s1Idx[LOW_W-1:0], {OFF_W{1'b0}}};
        wbAddr     <= {tagMem[s1Idx][victim], s1Idx[LOW_W-1:0], {OFF_W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.install) tagMem[missIdx][missWay] <= missPfn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        lruMem[s]   <= '0;
      end
    end else if (strobe.install) begin
      validMem[missIdx][missWay] <= 1'b1;
      dirtyMem[missIdx][missWay] <= 1'b0;
      lruMem[missIdx]            <= treeTouch(lruMem[missIdx], missWay);
    end else if (strobe.hitUpd) begin
      lruMem[s1Idx] <= treeTouch(lruMem[s1Idx], hitWay);
      if (strobe.hitWrite) dirtyMem[s1Idx][hitWay] <= 1'b1;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R3
  AST_INSTALL_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.install |-> !strobe.hitUpd && !strobe.missLatch); // R8
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.missLatch && !(&validRow)) |-> !validRow[victim]); // R6
endmodule

// File: rtl/vtag_control.sv
module vtag_control
  import vtag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             refillDone,
  input  logic             hit,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             victimNeedsWb,
  output ctlStrobe_t       strobe,
  output logic             busy,
  output logic             respValid,
  output logic             respHit,
  output logic [WAY_W-1:0] respWay,
  output logic             wbReq,
  output logic             refillReq
);
  logic s1Valid, s1Write, s1Miss, accept, missPending;

  assign s1Miss    = s1Valid && !hit;
  assign busy      = missPending || s1Miss;
  assign accept    = reqValid && !busy;
  assign refillReq = missPending;

  always_comb begin
    strobe           = '0;
    strobe.capture   = accept;
    strobe.hitUpd    = s1Valid && hit;
    strobe.hitWrite  = s1Write;
    strobe.missLatch = s1Miss;
    strobe.install   = missPending && refillDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid     <= 1'b0;
      s1Write     <= 1'b0;
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respWay     <= '0;
      missPending <= 1'b0;
      wbReq       <= 1'b0;
    end else begin
      s1Valid   <= accept;
      s1Write   <= accept && reqWrite;
      respValid <= s1Valid;
      respHit   <= s1Valid && hit;
      respWay   <= hitWay;
      if (s1Miss) begin
        missPending <= 1'b1;
        wbReq       <= victimNeedsWb;
      end else if (strobe.install) begin
        missPending <= 1'b0;
        wbReq       <= 1'b0;
      end
    end
  end

  AST_MISS_RAISES_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> refillReq); // R4
  AST_WB_WITH_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> refillReq); // R5
  AST_QUIET_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && $past(refillReq)) |-> !respValid); // R7
  AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && !refillDone) |=> refillReq); // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && refillDone) |=> !refillReq && !wbReq); // R8
endmodule

// File: rtl/vipt_tag_ctrl.sv
module vipt_tag_ctrl
  import vtag_pkg::*;
#(
  parameter int PFN_W  = 20,
  parameter int IDX_W  = 7,
  parameter int OFF_W  = 7,
  parameter int PAGE_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [IDX_W-1:0]        reqVaIndex,
  input  logic [PFN_W-1:0]        xlatPfn,
  output logic                    busy,
  output logic                    respValid,
  output logic                    respHit,
  output logic [WAY_W-1:0]        respWay,
  output logic                    wbReq,
  output logic [PFN_W+PAGE_W-1:0] wbAddr,
  output logic                    refillReq,
  output logic [PFN_W+PAGE_W-1:0] refillAddr,
  input  logic                    refillDone
);
  ctlStrobe_t       strobe;
  logic             hit, victimNeedsWb;
  logic [WAY_W-1:0] hitWay;

  vtag_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .refillDone(refillDone), .hit(hit), .hitWay(hitWay),
    .victimNeedsWb(victimNeedsWb), .strobe(strobe), .busy(busy),
    .respValid(respValid), .respHit(respHit), .respWay(respWay),
    .wbReq(wbReq), .refillReq(refillReq)
  );

  vtag_datapath #(.PFN_W(PFN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIdx(reqVaIndex),
    .xlatPfn(xlatPfn), .hit(hit), .hitWay(hitWay),
    .victimNeedsWb(victimNeedsWb), .wbAddr(wbAddr), .refillAddr(refillAddr)
  );
endmodule

// File: tb/vipt_tag_ctrl_test.sv
module vipt_tag_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [6:0]  reqVaIndex = '0;
  logic [19:0] xlatPfn = '0;
  logic        refillDone = 1'b0;
  logic        busy, respValid, respHit, wbReq, refillReq;
  logic [1:0]  respWay;
  logic [31:0] wbAddr, refillAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [6:0]  SET_A = 7'h65;  // top index bits 11
  localparam logic [6:0]  SET_B = 7'h25;  // same low five bits, top bits 01
  localparam logic [19:0] P0 = 20'hABC04, P1 = 20'hABC05, P2 = 20'h0F0F1,
                          P3 = 20'h55557, P4 = 20'h77778, P5 = 20'h31313,
                          P6 = 20'h4242A;

  always #10 clk = ~clk;  // 50 MHz

  vipt_tag_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqVaIndex(reqVaIndex), .xlatPfn(xlatPfn), .busy(busy),
    .respValid(respValid), .respHit(respHit), .respWay(respWay),
    .wbReq(wbReq), .wbAddr(wbAddr), .refillReq(refillReq),
    .refillAddr(refillAddr), .refillDone(refillDone)
  );

  function automatic logic [31:0] lineAddr(input logic [19:0] p, input logic [6:0] idx);
    return {p, idx[4:0], 7'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [6:0] idx, input logic wr, input logic [19:0] p);
    @(negedge clk);
    reqValid = 1'b1; reqVaIndex = idx; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; xlatPfn = p;
    @(negedge clk);
  endtask

  task automatic expectHit(input logic [1:0] way, input string req);
    check(respValid && respHit, req, {respValid, respHit}, 2'b11);
    check(respWay == way, req, respWay, way);
  endtask

  task automatic expectMiss(input logic [19:0] p, input logic [6:0] idx,
                            input string req);
    check(respValid && !respHit, req, {respValid, respHit}, 2'b10);
    check(refillReq && busy, {req, " R4 R7"}, {refillReq, busy}, 2'b11);
    check(refillAddr == lineAddr(p, idx), {req, " R4"}, refillAddr, lineAddr(p, idx));
  endtask

  task automatic refill(input string req);
    @(negedge clk); refillDone = 1'b1;
    @(negedge clk); refillDone = 1'b0;
    check(!refillReq && !wbReq && !busy, req, {refillReq, wbReq, busy}, 3'b000);
  endtask

  task automatic testReset;
    check(!busy && !respValid && !refillReq && !wbReq, "R1 idle outputs",
          {busy, respValid, refillReq, wbReq}, 4'b0);
  endtask

  task automatic testFirstMissAndStall;
    logic [31:0] heldAddr;
    lookup(SET_A, 1'b0, P0);
    expectMiss(P0, SET_A, "R1 first lookup misses");
    check(!wbReq, "R5 invalid victim no write-back", wbReq, 1'b0);
    heldAddr = refillAddr;
    @(negedge clk);
    reqValid = 1'b1; reqVaIndex = 7'h11; xlatPfn = P5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!respValid && busy, "R7 request ignored while busy", {respValid, busy}, 2'b01);
    end
    reqValid = 1'b0;
    check(refillAddr == heldAddr, "R7 refill address held", refillAddr, heldAddr);
    refill("R8 release after done");
    @(negedge clk);
    check(!respValid, "R7 ignored request gives no response", respValid, 1'b0);
  endtask

  task automatic testWriteHitAndFill;
    lookup(SET_A, 1'b1, P0);
    expectHit(2'd0, "R3 R9 write hit way0");
    lookup(SET_A, 1'b0, P1);  // differs only in bit 0 of the frame
    expectMiss(P1, SET_A, "R3 partial frame match misses");
    refill("R8 install way1");
    lookup(SET_A, 1'b0, P2);
    expectMiss(P2, SET_A, "R6 fill way2");
    refill("R8 install way2");
    lookup(SET_A, 1'b0, P3);
    expectMiss(P3, SET_A, "R6 fill way3");
    check(!wbReq, "R6 invalid way chosen before valid", wbReq, 1'b0);
    refill("R8 install way3");
  endtask

  task automatic testDirtyEviction;
    // tree after installs 0,1,2,3 points at way0, which is dirty
    lookup(SET_A, 1'b0, P4);
    expectMiss(P4, SET_A, "R6 full set evicts");
    check(wbReq, "R5 R9 dirty victim raises write-back", wbReq, 1'b1);
    check(wbAddr == lineAddr(P0, SET_A), "R5 write-back from stored tag",
          wbAddr, lineAddr(P0, SET_A));
    refill("R8 install over way0");
    lookup(SET_A, 1'b0, P4);
    expectHit(2'd0, "R8 installed in held set way0");
  endtask

  task automatic testAlias;
    lookup(SET_B, 1'b0, P4);
    expectMiss(P4, SET_B, "R2 upper index bits select another set");
    check(!wbReq, "R2 other set empty", wbReq, 1'b0);
    refill("R8 install in alias set");
    lookup(SET_B, 1'b0, P4);
    expectHit(2'd0, "R2 alias set hit");
    lookup(SET_A, 1'b0, P4);
    expectHit(2'd0, "R2 original set untouched");
  endtask

  task automatic testTreeOrder;
    lookup(SET_A, 1'b0, P1);
    expectHit(2'd1, "R3 hit way1");
    lookup(SET_A, 1'b0, P2);
    expectHit(2'd2, "R3 hit way2");
    // tree now points at way0, installed clean
    lookup(SET_A, 1'b0, P5);
    expectMiss(P5, SET_A, "R10 victim after hits");
    check(wbAddr == lineAddr(P4, SET_A), "R10 way0 chosen", wbAddr, lineAddr(P4, SET_A));
    check(!wbReq, "R8 installed line is clean", wbReq, 1'b0);
    refill("R8 install way0 again");
    lookup(SET_A, 1'b0, P6);
    expectMiss(P6, SET_A, "R6 tree victim");
    check(wbAddr == lineAddr(P3, SET_A), "R6 R10 way3 chosen", wbAddr, lineAddr(P3, SET_A));
    refill("R8 install way3");
    lookup(SET_A, 1'b0, P6);
    expectHit(2'd3, "R8 new tag in way3");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstMissAndStall();
    testWriteHitAndFill();
    testDirtyEviction();
    testAlias();
    testTreeOrder();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule